// File: doc/BRIEF.md
# Serial-Wire Debug Memory Access Sequencer

This block sits above a serial-wire debug packet engine and turns single high-level commands into the ordered list of engine transactions that a debug host needs. Four commands exist: bring the link up, power up the debug domain, write one 32-bit word into target memory, and read a burst of words from target memory. For each command the block walks a fixed list of steps. A step is a line reset, a run of idle clocks, or one request packet with its own trailing-clock count. The block issues the steps one at a time to the engine and waits for each response before moving on.

Reads from the memory access port are posted, so the first successful data read of a burst returns stale data and is dropped. Each later successful read is delivered on a valid/ready stream. A WAIT acknowledge makes the block repeat the same packet, and a FAULT acknowledge ends the command. When a command ends, the block gives a one-cycle status: success or fault, together with the number of burst words not yet delivered.

Top module: `swd_mem_seq`

## Requirements
- R1: Op code 0 (connect) issues, in order: line resets (kind 1) with 56, 59 and 59 high cycles on `eng_req_cycles`, then idle clocks (kind 2) with 16 cycles, then a packet (kind 0) that reads debug-port register 0 (ap=0, rnw=1, addr=0) with 6 trailing clocks. After each line reset the engine adds 16 low cycles.
- R2: Op code 1 (debug power-up) issues two debug-port writes, both with 7 trailing clocks: 0x0000001E to register 0, then 0x50000000 to register 1.
- R3: Op code 2 (word write) issues six packets in this order: DP reg 0 write 0x1E (trail 7), DP reg 2 write 0 (trail 0), AP reg 0 write 0x23000012 (trail 0), AP reg 1 write of the address (trail 0), AP reg 3 write of the value (trail 7), then DP reg 3 read (trail 3).
- R4: Op code 3 (burst read) issues the first four packets of R3 and then repeats AP reg 3 reads with 3 trailing clocks. If the length is zero, it ends after the four setup packets.
- R5: In a burst, the first AP reg 3 read that is acknowledged OK (ack 3'b001) delivers nothing. Each later OK read delivers its data as one word and lowers the remaining count by one. Word j is the response data of the (j+2)-th OK read.
- R6: A WAIT acknowledge (3'b010) to any packet makes the block re-issue the identical request, and the remaining count does not change.
- R7: A FAULT acknowledge (3'b100) or any other non-OK, non-WAIT code ends the command at once. The status then shows `done_fault`=1 and `done_left` equal to the number of words still outstanding.
- R8: A command that completes shows a one-cycle `done_valid` with `done_fault`=0 and `done_left`=0. The acknowledge of line-reset and idle steps is ignored.
- R9: A delivered word keeps `rd_valid` and `rd_data` unchanged while `rd_ready` is low. No engine request is raised while a word is waiting to be accepted.
- R10: A command is taken only while `busy` is low. A `cmd_valid` during `busy` has no effect on the running command and raises `cmd_err` for one cycle, in the next cycle.
- R11: During and after reset, `busy`, `eng_req_valid`, `rd_valid`, `done_valid` and `cmd_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 connect, 1 power-up, 2 word write, 3 burst read |
| cmd_addr | input | 32 | Target memory address |
| cmd_wdata | input | 32 | Value for word write |
| cmd_len | input | LEN_W | Word count for burst read |
| busy | output | 1 | Command in progress |
| cmd_err | output | 1 | Command strobe arrived while busy |
| eng_req_valid | output | 1 | Engine request valid, held until ready |
| eng_req_ready | input | 1 | Engine takes request |
| eng_req_kind | output | 2 | 0 packet, 1 line reset, 2 idle clocks |
| eng_req_ap | output | 1 | Access port (1) or debug port (0) |
| eng_req_rnw | output | 1 | Read (1) or write (0) |
| eng_req_addr | output | 2 | Register address bits 3:2 |
| eng_req_wdata | output | 32 | Write data |
| eng_req_trail | output | 4 | Trailing clocks after packet |
| eng_req_cycles | output | 8 | High cycles of line reset, or idle clock count |
| eng_rsp_valid | input | 1 | Engine response strobe, one per taken request |
| eng_rsp_ack | input | 3 | Acknowledge code |
| eng_rsp_rdata | input | 32 | Read data |
| rd_valid | output | 1 | Burst word valid |
| rd_ready | input | 1 | Burst word accepted |
| rd_data | output | 32 | Burst word |
| done_valid | output | 1 | One-cycle completion strobe |
| done_fault | output | 1 | Command ended by fault |
| done_left | output | LEN_W | Words not delivered |

## Verification
Each command is run against a scripted engine model, and the full list of requests it records is compared with the expected list. This separates the four step orders and shows every address, data word and trailing count. Burst reads are tried with length zero, with length three behind a stalling consumer, with a WAIT on a data read, and with a FAULT in the middle of a burst. These cases show apart the dropped posted read, the repeated packet that leaves the count alone, and the early end with the correct remaining count. WAIT and FAULT are also placed on setup packets of writes and on the connect read, and a command strobe is sent into a running burst to show that it leaves the transaction list unchanged.

// File: rtl/swd_seq_pkg.sv
// Shared types and constants for the debug memory access sequencer.
// Assumes a 32-bit debug data word and at most six steps per command.
package swd_seq_pkg;

    localparam int WORD_W     = 32;
    localparam int STEP_IDX_W = 3;
    localparam int TRAIL_W    = 4;
    localparam int CYC_W      = 8;
    localparam int ACK_W      = 3;

    typedef enum logic [1:0] {
        OP_CONNECT = 2'd0,
        OP_PWRUP   = 2'd1,
        OP_WRITE   = 2'd2,
        OP_BURST   = 2'd3
    } seq_op_e;

    typedef enum logic [1:0] {
        KIND_PACKET = 2'd0,
        KIND_LRESET = 2'd1,
        KIND_IDLE   = 2'd2
    } step_kind_e;

    localparam logic [ACK_W-1:0] ACK_OK   = 3'b001;
    localparam logic [ACK_W-1:0] ACK_WAIT = 3'b010;

    localparam logic [WORD_W-1:0] ABORT_CLR  = 32'h0000_001E;
    localparam logic [WORD_W-1:0] PWRUP_REQ  = 32'h5000_0000;
    localparam logic [WORD_W-1:0] MEMAP_CTRL = 32'h2300_0012;

    typedef struct packed {
        step_kind_e          kind;
        logic                ap;
        logic                rnw;
        logic [1:0]          reg_a;
        logic [WORD_W-1:0]   wdata;
        logic [TRAIL_W-1:0]  trail;
        logic [CYC_W-1:0]    cycles;
        logic                last;
        logic                loop;
    } step_t;

    // Build a packet step.
    function automatic step_t pkt_step(input logic ap, input logic rnw,
                                       input logic [1:0] a,
                                       input logic [WORD_W-1:0] wd,
                                       input logic [TRAIL_W-1:0] tr,
                                       input logic last, input logic loop);
        step_t s;
        s.kind   = KIND_PACKET;
        s.ap     = ap;
        s.rnw    = rnw;
        s.reg_a  = a;
        s.wdata  = wd;
        s.trail  = tr;
        s.cycles = '0;
        s.last   = last;
        s.loop   = loop;
        return s;
    endfunction

    // Build a line-reset or idle-clock step.
    function automatic step_t ctl_step(input step_kind_e k,
                                       input logic [CYC_W-1:0] cy);
        step_t s;
        s.kind   = k;
        s.ap     = 1'b0;
        s.rnw    = 1'b0;
        s.reg_a  = 2'd0;
        s.wdata  = '0;
        s.trail  = '0;
        s.cycles = cy;
        s.last   = 1'b0;
        s.loop   = 1'b0;
        return s;
    endfunction

endpackage

// File: rtl/swd_step_decode.sv
// Step table: maps the current command and step index to the engine request.
// Purely combinational. Assumes the index never passes the last step of a
// command; the burst loop step (index 4 of op 3) is repeated by the caller.
module swd_step_decode
    import swd_seq_pkg::*;
#(
    parameter int RST_HI_A = 56,
    parameter int RST_HI_B = 59,
    parameter int IDLE_GAP = 16
) (
    input  seq_op_e                op,
    input  logic [STEP_IDX_W-1:0]  idx,
    input  logic [WORD_W-1:0]      addr,
    input  logic [WORD_W-1:0]      wdata,
    input  logic                   len_zero,
    output step_t                  step
);

    localparam logic [CYC_W-1:0] HI_A = CYC_W'(RST_HI_A);
    localparam logic [CYC_W-1:0] HI_B = CYC_W'(RST_HI_B);
    localparam logic [CYC_W-1:0] GAP  = CYC_W'(IDLE_GAP);

    // Pick the step record for (op, idx).
    always_comb begin
        step = ctl_step(KIND_IDLE, '0);
        step.last = 1'b1;
        unique case (op)
            OP_CONNECT: begin
                case (idx)
                    3'd0:    step = ctl_step(KIND_LRESET, HI_A);
                    3'd1:    step = ctl_step(KIND_LRESET, HI_B);
                    3'd2:    step = ctl_step(KIND_LRESET, HI_B);
                    3'd3:    step = ctl_step(KIND_IDLE, GAP);
                    default: step = pkt_step(1'b0, 1'b1, 2'd0, '0, 4'd6, 1'b1, 1'b0);
                endcase
            end
            OP_PWRUP: begin
                if (idx == 3'd0)
                    step = pkt_step(1'b0, 1'b0, 2'd0, ABORT_CLR, 4'd7, 1'b0, 1'b0);
                else
                    step = pkt_step(1'b0, 1'b0, 2'd1, PWRUP_REQ, 4'd7, 1'b1, 1'b0);
            end
            OP_WRITE, OP_BURST: begin
                case (idx)
                    3'd0: step = pkt_step(1'b0, 1'b0, 2'd0, ABORT_CLR, 4'd7, 1'b0, 1'b0);
                    3'd1: step = pkt_step(1'b0, 1'b0, 2'd2, '0, 4'd0, 1'b0, 1'b0);
                    3'd2: step = pkt_step(1'b1, 1'b0, 2'd0, MEMAP_CTRL, 4'd0, 1'b0, 1'b0);
                    3'd3: step = pkt_step(1'b1, 1'b0, 2'd1, addr, 4'd0,
                                          (op == OP_BURST) && len_zero, 1'b0);
                    3'd4: begin
                        if (op == OP_WRITE)
                            step = pkt_step(1'b1, 1'b0, 2'd3, wdata, 4'd7, 1'b0, 1'b0);
                        else
                            step = pkt_step(1'b1, 1'b1, 2'd3, '0, 4'd3, 1'b0, 1'b1);
                    end
                    default: step = pkt_step(1'b0, 1'b1, 2'd3, '0, 4'd3, 1'b1, 1'b0);
                endcase
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/swd_burst_track.sv
// Burst word tracker: drops the first posted read, registers each later read
// as an output word held until accepted, and counts the words still owed.
// Assumes no loop response arrives while a word is waiting.
module swd_burst_track
    import swd_seq_pkg::*;
#(
    parameter int LEN_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [LEN_W-1:0]    load_len,
    input  logic                loop_ok,
    input  logic [WORD_W-1:0]   rsp_data,
    input  logic                rd_ready,
    output logic                deliver,
    output logic [LEN_W-1:0]    remaining,
    output logic                rd_valid,
    output logic [WORD_W-1:0]   rd_data
);

    logic first_q;

    // A loop read yields a word unless it is the stale posted one.
    assign deliver = loop_ok && !first_q;

    // Track the posted-read flag and the outstanding count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            first_q   <= 1'b1;
            remaining <= '0;
        end else if (load) begin
            first_q   <= 1'b1;
            remaining <= load_len;
        end else if (loop_ok) begin
            first_q <= 1'b0;
            if (!first_q)
                remaining <= remaining - 1'b1;
        end
    end

    // Output word register with valid/ready hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else if (deliver) begin
            rd_valid <= 1'b1;
            rd_data  <= rsp_data;
        end else if (rd_ready) begin
            rd_valid <= 1'b0;
        end
    end

endmodule

// File: rtl/swd_mem_seq.sv
// Debug memory access sequencer top. Takes one command while idle, walks its
// step list through the engine request/response port, retries on WAIT, stops
// on FAULT, and reports a one-cycle completion status. Assumes the engine
// returns exactly one response per accepted request, never in the same cycle.
module swd_mem_seq
    import swd_seq_pkg::*;
#(
    parameter int LEN_W    = 8,
    parameter int RST_HI_A = 56,
    parameter int RST_HI_B = 59,
    parameter int IDLE_GAP = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [31:0]         cmd_addr,
    input  logic [31:0]         cmd_wdata,
    input  logic [LEN_W-1:0]    cmd_len,
    output logic                busy,
    output logic                cmd_err,
    output logic                eng_req_valid,
    input  logic                eng_req_ready,
    output logic [1:0]          eng_req_kind,
    output logic                eng_req_ap,
    output logic                eng_req_rnw,
    output logic [1:0]          eng_req_addr,
    output logic [31:0]         eng_req_wdata,
    output logic [3:0]          eng_req_trail,
    output logic [7:0]          eng_req_cycles,
    input  logic                eng_rsp_valid,
    input  logic [2:0]          eng_rsp_ack,
    input  logic [31:0]         eng_rsp_rdata,
    output logic                rd_valid,
    input  logic                rd_ready,
    output logic [31:0]         rd_data,
    output logic                done_valid,
    output logic                done_fault,
    output logic [LEN_W-1:0]    done_left
);

    typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_RESP, S_HOLD} seq_state_e;

    seq_state_e              st_q;
    seq_op_e                 op_q;
    logic [WORD_W-1:0]       addr_q;
    logic [WORD_W-1:0]       wdata_q;
    logic [STEP_IDX_W-1:0]   idx_q;
    step_t                   step;
    logic [LEN_W-1:0]        remaining;
    logic                    deliver;
    logic                    take_cmd;
    logic                    is_pkt;
    logic                    rsp_ok;
    logic                    rsp_wait;
    logic                    loop_ok;

    assign take_cmd = (st_q == S_IDLE) && cmd_valid;
    assign is_pkt   = (step.kind == KIND_PACKET);
    assign rsp_ok   = eng_rsp_valid && (!is_pkt || (eng_rsp_ack == ACK_OK));
    assign rsp_wait = eng_rsp_valid && is_pkt && (eng_rsp_ack == ACK_WAIT);
    assign loop_ok  = (st_q == S_RESP) && rsp_ok && step.loop;

    swd_step_decode #(
        .RST_HI_A (RST_HI_A),
        .RST_HI_B (RST_HI_B),
        .IDLE_GAP (IDLE_GAP)
    ) u_decode (
        .op       (op_q),
        .idx      (idx_q),
        .addr     (addr_q),
        .wdata    (wdata_q),
        .len_zero (remaining == '0),
        .step     (step)
    );

    swd_burst_track #(
        .LEN_W (LEN_W)
    ) u_burst (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (take_cmd),
        .load_len  ((seq_op_e'(cmd_op) == OP_BURST) ? cmd_len : '0),
        .loop_ok   (loop_ok),
        .rsp_data  (eng_rsp_rdata),
        .rd_ready  (rd_ready),
        .deliver   (deliver),
        .remaining (remaining),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    // Engine request fields come straight from the decoded step.
    assign eng_req_valid  = (st_q == S_ISSUE);
    assign eng_req_kind   = step.kind;
    assign eng_req_ap     = step.ap;
    assign eng_req_rnw    = step.rnw;
    assign eng_req_addr   = step.reg_a;
    assign eng_req_wdata  = step.wdata;
    assign eng_req_trail  = step.trail;
    assign eng_req_cycles = step.cycles;
    assign busy           = (st_q != S_IDLE);

    // Command capture and step sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= S_IDLE;
            op_q    <= OP_CONNECT;
            addr_q  <= '0;
            wdata_q <= '0;
            idx_q   <= '0;
        end else begin
            unique case (st_q)
                S_IDLE: begin
                    if (cmd_valid) begin
                        op_q    <= seq_op_e'(cmd_op);
                        addr_q  <= cmd_addr;
                        wdata_q <= cmd_wdata;
                        idx_q   <= '0;
                        st_q    <= S_ISSUE;
                    end
                end
                S_ISSUE: begin
                    if (eng_req_ready)
                        st_q <= S_RESP;
                end
                S_RESP: begin
                    if (eng_rsp_valid) begin
                        if (rsp_wait)
                            st_q <= S_ISSUE;
                        else if (!rsp_ok)
                            st_q <= S_IDLE;
                        else if (step.loop)
                            st_q <= deliver ? S_HOLD : S_ISSUE;
                        else if (step.last)
                            st_q <= S_IDLE;
                        else begin
                            idx_q <= idx_q + 1'b1;
                            st_q  <= S_ISSUE;
                        end
                    end
                end
                S_HOLD: begin
                    if (rd_ready)
                        st_q <= (remaining == '0) ? S_IDLE : S_ISSUE;
                end
                default: st_q <= S_IDLE;
            endcase
        end
    end

    // Completion status strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_valid <= 1'b0;
            done_fault <= 1'b0;
            done_left  <= '0;
        end else begin
            done_valid <= 1'b0;
            if ((st_q == S_RESP) && eng_rsp_valid && !rsp_wait && !rsp_ok) begin
                done_valid <= 1'b1;
                done_fault <= 1'b1;
                done_left  <= remaining;
            end else if (((st_q == S_RESP) && rsp_ok && !step.loop && step.last) ||
                         ((st_q == S_HOLD) && rd_ready && (remaining == '0))) begin
                done_valid <= 1'b1;
                done_fault <= 1'b0;
                done_left  <= '0;
            end
        end
    end

    // Flag a command strobe that arrives while a command runs.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cmd_err <= 1'b0;
        else
            cmd_err <= cmd_valid && (st_q != S_IDLE);
    end

endmodule

// File: rtl/swd_mem_seq_chk.sv
// Protocol checker for the sequencer ports, bound to every instance.
module swd_mem_seq_chk #(
    parameter int LEN_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cmd_valid,
    input logic              busy,
    input logic              cmd_err,
    input logic              eng_req_valid,
    input logic              eng_req_ready,
    input logic [1:0]        eng_req_kind,
    input logic              eng_req_ap,
    input logic              eng_req_rnw,
    input logic [1:0]        eng_req_addr,
    input logic [31:0]       eng_req_wdata,
    input logic [3:0]        eng_req_trail,
    input logic [7:0]        eng_req_cycles,
    input logic              rd_valid,
    input logic              rd_ready,
    input logic [31:0]       rd_data,
    input logic              done_valid,
    input logic              done_fault,
    input logic [LEN_W-1:0]  done_left
);

    // R9
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && !rd_ready |=> rd_valid && $stable(rd_data));

    // R9
    no_req_while_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !eng_req_valid);

    // R10
    busy_strobe_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && busy |=> cmd_err);

    // R10
    idle_no_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |=> !cmd_err);

    // R8
    ok_left_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid && !done_fault |-> done_left == '0);

    // R8
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> !busy);

    // R6
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid && !eng_req_ready |=> eng_req_valid &&
        $stable({eng_req_kind, eng_req_ap, eng_req_rnw, eng_req_addr,
                 eng_req_wdata, eng_req_trail, eng_req_cycles}));

    // R11
    req_needs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_req_valid |-> busy);

endmodule

bind swd_mem_seq swd_mem_seq_chk #(.LEN_W(LEN_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cmd_valid      (cmd_valid),
    .busy           (busy),
    .cmd_err        (cmd_err),
    .eng_req_valid  (eng_req_valid),
    .eng_req_ready  (eng_req_ready),
    .eng_req_kind   (eng_req_kind),
    .eng_req_ap     (eng_req_ap),
    .eng_req_rnw    (eng_req_rnw),
    .eng_req_addr   (eng_req_addr),
    .eng_req_wdata  (eng_req_wdata),
    .eng_req_trail  (eng_req_trail),
    .eng_req_cycles (eng_req_cycles),
    .rd_valid       (rd_valid),
    .rd_ready       (rd_ready),
    .rd_data        (rd_data),
    .done_valid     (done_valid),
    .done_fault     (done_fault),
    .done_left      (done_left)
);

// File: tb/test_swd_mem_seq.sv
// Bench: scripted engine model, vector table of commands, directed cases.
module test_swd_mem_seq;

    localparam int CLK_PERIOD = 10;
    localparam int LEN_W      = 8;
    localparam int MAXLOG     = 64;
    localparam int WDOG       = 150000;

    typedef struct packed {
        logic [1:0]  op;
        logic [31:0] addr;
        logic [31:0] wdata;
        logic [7:0]  len;
        logic [7:0]  fault_at;
        logic [7:0]  wait_at;
        logic [7:0]  exp_nreq;
        logic        exp_fault;
        logic [7:0]  exp_left;
        logic        stall;
    } vec_t;

    localparam int NVEC = 10;
    localparam vec_t VECS [NVEC] = '{
        // connect (R1)
        '{2'd0, 32'h0, 32'h0, 8'd0, 8'hFF, 8'hFF, 8'd5, 1'b0, 8'd0, 1'b0},
        // power-up (R2)
        '{2'd1, 32'h0, 32'h0, 8'd0, 8'hFF, 8'hFF, 8'd2, 1'b0, 8'd0, 1'b1},
        // word write (R3)
        '{2'd2, 32'h5000_0008, 32'h0900_0803, 8'd0, 8'hFF, 8'hFF, 8'd6, 1'b0, 8'd0, 1'b0},
        // burst of 3, stalling consumer (R4, R5, R9)
        '{2'd3, 32'h2000_0000, 32'h0, 8'd3, 8'hFF, 8'hFF, 8'd8, 1'b0, 8'd0, 1'b1},
        // burst of 2, WAIT on first word read (R6)
        '{2'd3, 32'h2000_0100, 32'h0, 8'd2, 8'hFF, 8'd5, 8'd8, 1'b0, 8'd0, 1'b0},
        // burst of 4, FAULT on second word read (R7)
        '{2'd3, 32'h2000_0200, 32'h0, 8'd4, 8'd6, 8'hFF, 8'd7, 1'b1, 8'd3, 1'b0},
        // burst of 0 (R4)
        '{2'd3, 32'h2000_0300, 32'h0, 8'd0, 8'hFF, 8'hFF, 8'd4, 1'b0, 8'd0, 1'b0},
        // write, FAULT on third packet (R7)
        '{2'd2, 32'h5000_0010, 32'h0000_1000, 8'd0, 8'd2, 8'hFF, 8'd3, 1'b1, 8'd0, 1'b0},
        // write, WAIT on first packet (R6)
        '{2'd2, 32'h5000_0010, 32'h0000_1000, 8'd0, 8'hFF, 8'd0, 8'd7, 1'b0, 8'd0, 1'b1},
        // connect, WAIT on identity read (R6)
        '{2'd0, 32'h0, 32'h0, 8'd0, 8'hFF, 8'd4, 8'd6, 1'b0, 8'd0, 1'b0}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic [1:0]        cmd_op = '0;
    logic [31:0]       cmd_addr = '0;
    logic [31:0]       cmd_wdata = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              busy, cmd_err;
    logic              eng_req_valid;
    logic              eng_req_ready = 1'b1;
    logic [1:0]        eng_req_kind;
    logic              eng_req_ap, eng_req_rnw;
    logic [1:0]        eng_req_addr;
    logic [31:0]       eng_req_wdata;
    logic [3:0]        eng_req_trail;
    logic [7:0]        eng_req_cycles;
    logic              eng_rsp_valid = 1'b0;
    logic [2:0]        eng_rsp_ack = 3'b001;
    logic [31:0]       eng_rsp_rdata = '0;
    logic              rd_valid;
    logic              rd_ready = 1'b1;
    logic [31:0]       rd_data;
    logic              done_valid, done_fault;
    logic [LEN_W-1:0]  done_left;

    always #(CLK_PERIOD/2) clk = ~clk;

    swd_mem_seq #(.LEN_W(LEN_W)) i_swd_mem_seq (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_wdata(cmd_wdata), .cmd_len(cmd_len),
        .busy(busy), .cmd_err(cmd_err),
        .eng_req_valid(eng_req_valid), .eng_req_ready(eng_req_ready),
        .eng_req_kind(eng_req_kind), .eng_req_ap(eng_req_ap),
        .eng_req_rnw(eng_req_rnw), .eng_req_addr(eng_req_addr),
        .eng_req_wdata(eng_req_wdata), .eng_req_trail(eng_req_trail),
        .eng_req_cycles(eng_req_cycles),
        .eng_rsp_valid(eng_rsp_valid), .eng_rsp_ack(eng_rsp_ack),
        .eng_rsp_rdata(eng_rsp_rdata),
        .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
        .done_valid(done_valid), .done_fault(done_fault), .done_left(done_left)
    );

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    // engine model state
    logic [49:0] req_log [MAXLOG];
    int          n_log = 0;
    int          ok_reads = 0;
    int          fault_at = 255;
    int          wait_at  = 255;
    logic        stall_mode = 1'b0;
    logic        rsp_pending = 1'b0;
    logic [2:0]  pend_ack = 3'b001;
    logic [31:0] pend_data = '0;
    logic [31:0] words [MAXLOG];
    int          n_words = 0;
    int          hold_err = 0;
    int          overlap_err = 0;
    logic        word_waiting = 1'b0;
    logic [31:0] word_last = '0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [49:0] pk(input logic [1:0] k, input logic ap,
                                       input logic rnw, input logic [1:0] a,
                                       input logic [31:0] wd, input logic [3:0] tr,
                                       input logic [7:0] cy);
        return {k, ap, rnw, a, wd, tr, cy};
    endfunction

    // Expected request for step s of a command, from the requirements.
    function automatic logic [49:0] exp_req(input logic [1:0] op, input int s,
                                            input logic [31:0] addr,
                                            input logic [31:0] wd);
        if (op == 2'd0) begin
            if (s == 0) return pk(2'd1, 0, 0, 2'd0, 0, 0, 8'd56);
            if (s <= 2) return pk(2'd1, 0, 0, 2'd0, 0, 0, 8'd59);
            if (s == 3) return pk(2'd2, 0, 0, 2'd0, 0, 0, 8'd16);
            return pk(2'd0, 0, 1, 2'd0, 0, 4'd6, 0);
        end
        if (op == 2'd1) begin
            if (s == 0) return pk(2'd0, 0, 0, 2'd0, 32'h1E, 4'd7, 0);
            return pk(2'd0, 0, 0, 2'd1, 32'h5000_0000, 4'd7, 0);
        end
        case (s)
            0: return pk(2'd0, 0, 0, 2'd0, 32'h1E, 4'd7, 0);
            1: return pk(2'd0, 0, 0, 2'd2, 0, 4'd0, 0);
            2: return pk(2'd0, 1, 0, 2'd0, 32'h2300_0012, 4'd0, 0);
            3: return pk(2'd0, 1, 0, 2'd1, addr, 4'd0, 0);
            4: return (op == 2'd2) ? pk(2'd0, 1, 0, 2'd3, wd, 4'd7, 0)
                                   : pk(2'd0, 1, 1, 2'd3, 0, 4'd3, 0);
            default: return pk(2'd0, 0, 1, 2'd3, 0, 4'd3, 0);
        endcase
    endfunction

    function automatic string op_tag(input logic [1:0] op);
        case (op)
            2'd0: return "R1";
            2'd1: return "R2";
            2'd2: return "R3";
            default: return "R4";
        endcase
    endfunction

    // Engine model and consumer, all on the falling edge.
    always @(negedge clk) begin
        cyc++;
        if (cyc > WDOG) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected fewer than %0d", cyc, WDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
        if (eng_rsp_valid) eng_rsp_valid = 1'b0;
        if (rsp_pending) begin
            eng_rsp_valid = 1'b1;
            eng_rsp_ack   = pend_ack;
            eng_rsp_rdata = pend_data;
            rsp_pending   = 1'b0;
        end
        if (rd_valid && eng_req_valid) overlap_err++;
        eng_req_ready = stall_mode ? cyc[0] : 1'b1;
        if (rst_n && eng_req_valid && eng_req_ready) begin
            pend_ack = (n_log == fault_at) ? 3'b100 :
                       (n_log == wait_at)  ? 3'b010 : 3'b001;
            pend_data = 32'hCAFE_0000;
            if (eng_req_kind == 2'd0 && eng_req_ap && eng_req_rnw &&
                eng_req_addr == 2'd3 && pend_ack == 3'b001) begin
                pend_data = 32'hD000_0000 | ok_reads;
                ok_reads++;
            end
            if (n_log < MAXLOG)
                req_log[n_log] = {eng_req_kind, eng_req_ap, eng_req_rnw, eng_req_addr,
                                  eng_req_wdata, eng_req_trail, eng_req_cycles};
            n_log++;
            rsp_pending = 1'b1;
        end
        if (word_waiting && rd_valid && rd_data != word_last) hold_err++;
        rd_ready = stall_mode ? (cyc % 3 == 0) : 1'b1;
        if (rd_valid && rd_ready && n_words < MAXLOG) begin
            words[n_words] = rd_data;
            n_words++;
        end
        word_waiting = rd_valid && !rd_ready;
        word_last    = rd_data;
    end

    task automatic start_cmd(input vec_t v);
        @(negedge clk);
        n_log = 0; ok_reads = 0; n_words = 0;
        fault_at = int'(v.fault_at); wait_at = int'(v.wait_at);
        stall_mode = v.stall;
        cmd_valid = 1'b1; cmd_op = v.op; cmd_addr = v.addr;
        cmd_wdata = v.wdata; cmd_len = v.len;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    task automatic wait_done(output logic f, output logic [7:0] left);
        int n = 0;
        while (!done_valid && n < 4000) begin
            @(negedge clk);
            n++;
        end
        f = done_fault; left = done_left;
        check(done_valid, "R8", "completion strobe seen", 0, 1);
    endtask

    task automatic check_cmd(input vec_t v, input logic f, input logic [7:0] left);
        int s = 0;
        int bad = -1;
        int exp_words;
        check(n_log == int'(v.exp_nreq), op_tag(v.op), "request count", n_log, v.exp_nreq);
        for (int i = 0; i < n_log && i < MAXLOG; i++) begin
            if (bad < 0 && req_log[i] != exp_req(v.op, s, v.addr, v.wdata)) bad = i;
            if (i != int'(v.wait_at)) s = (v.op == 2'd3 && s >= 4) ? 4 : s + 1;
        end
        if (bad >= 0)
            check(0, op_tag(v.op), "request sequence", req_log[bad],
                  exp_req(v.op, 0, v.addr, v.wdata));
        else
            check(1, op_tag(v.op), "request sequence", 0, 0);
        check(f == v.exp_fault, v.exp_fault ? "R7" : "R8", "done_fault", f, v.exp_fault);
        check(left == v.exp_left, v.exp_fault ? "R7" : "R8", "done_left", left, v.exp_left);
        exp_words = int'(v.len) - int'(v.exp_left);
        check(n_words == exp_words, "R5", "words delivered", n_words, exp_words);
        bad = -1;
        for (int j = 0; j < n_words && j < MAXLOG; j++)
            if (bad < 0 && words[j] != (32'hD000_0000 | (j + 1))) bad = j;
        if (bad >= 0)
            check(0, "R5", "word value", words[bad], 32'hD000_0000 | (bad + 1));
        else
            check(1, "R5", "word value", 0, 0);
    endtask

    initial begin
        logic f;
        logic [7:0] left;
        vec_t v;
        // R11: reset state
        repeat (3) @(negedge clk);
        check(!busy && !eng_req_valid && !rd_valid && !done_valid && !cmd_err,
              "R11", "outputs in reset",
              {busy, eng_req_valid, rd_valid, done_valid, cmd_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!busy && !eng_req_valid && !rd_valid && !done_valid && !cmd_err,
              "R11", "outputs after reset",
              {busy, eng_req_valid, rd_valid, done_valid, cmd_err}, 0);

        for (int k = 0; k < NVEC; k++) begin
            start_cmd(VECS[k]);
            wait_done(f, left);
            check_cmd(VECS[k], f, left);
            repeat (2) @(negedge clk);
        end

        // R10: strobe during a running burst is ignored and flagged
        v = '{2'd3, 32'h3000_0000, 32'h0, 8'd2, 8'hFF, 8'hFF, 8'd7, 1'b0, 8'd0, 1'b1};
        start_cmd(v);
        repeat (3) @(negedge clk);
        check(busy, "R10", "busy while running", busy, 1);
        cmd_valid = 1'b1; cmd_op = 2'd0; cmd_len = 8'd9;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_err, "R10", "cmd_err after strobe while busy", cmd_err, 1);
        @(negedge clk);
        check(!cmd_err, "R10", "cmd_err one cycle", cmd_err, 0);
        wait_done(f, left);
        check_cmd(v, f, left);
        @(negedge clk);
        check(!busy && !cmd_err, "R10", "idle after ignored strobe", busy, 0);

        // R9: hold and no-overlap observed across all runs
        check(hold_err == 0, "R9", "word changed while stalled", hold_err, 0);
        check(overlap_err == 0, "R9", "request while word waiting", overlap_err, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule